// File: doc/BRIEF.md
# Gain-Ranging Input Exponent Normalizer

This block sits directly behind a gain-ranging ADC. Each input beat carries a 16-bit two's-complement sample and a 3-bit range code that reports which gain setting the converter used. The block puts every sample back on one common scale. It does this with an arithmetic right shift, and the shift amount comes from the range code. The shift is taken modulo 8. It is built from the code, an optional inversion of the code, and a programmable offset. With these, any chosen range, usually the largest, can be placed at zero shift. Each shift position takes 6 dB off the sample.

Samples enter and leave on valid/ready streams. A single register stage holds the normalized result. A beat is accepted when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the output beat is held unchanged and no new input is taken. Two configuration fields, the direction and the offset, are loaded through a plain write strobe.

Top module: `gr_exp_normalizer`

## Requirements
- R1: When the direction bit is 0, the right-shift amount is (code + offset) mod 8.
- R2: When the direction bit is 1, the right-shift amount is (7 - code + offset) mod 8.
- R3: The shift is arithmetic. Bits vacated at the top take the copy of the sample's bit 15, so negative samples stay negative.
- R4: With direction 1 and offset 6, codes 5, 4, 3, 2, 1 and 0 give shifts of 0, 1, 2, 3, 4 and 5.
- R5: With direction 1 and offset 5, code 4 gives zero shift and code 0 gives a shift of 4.
- R6: A beat accepted at a clock edge is shown on `out_data` with `out_valid` high from that edge on. If the output is drained with no new beat accepted, `out_valid` falls at that edge.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data` holds its value.
- R8: A configuration written at an edge is used by every beat accepted at later edges. A beat accepted at the same edge as the write still uses the earlier setting.
- R9: After reset, `out_valid` is 0, `in_ready` is 1, and the direction and offset are both 0. The first sample is therefore shifted by its own code.
- R10: While `cfg_we` is 0, the values on `cfg_invert` and `cfg_offset` have no effect on the shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load strobe for the direction and offset fields |
| cfg_invert | input | 1 | Direction to load: 1 uses 7 - code |
| cfg_offset | input | 3 | Offset to load |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take the input beat |
| in_data | input | 16 | Two's-complement sample from the converter |
| in_exp | input | 3 | Range code that goes with the sample |
| out_valid | output | 1 | Normalized beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_data | output | 16 | Normalized sample |

## Verification
Four properties are checked on every cycle by the assertions:
- the output holds steady and input is refused while the consumer stalls;
- an accepted beat always appears one edge later;
- the output slot empties after an unanswered drain;
- the sign bit survives the shift.

The shift amount itself is checked only by the bench. It sweeps both directions, all eight offsets and all eight codes over several sample patterns, and compares each result with a shift it computes itself. The bench also covers the timing of configuration writes against accepted beats and the state just after reset.

// File: rtl/gr_norm_pkg.sv
package gr_norm_pkg;

  parameter int unsigned GRN_CODE_W = 3;

  typedef enum logic {
    GRN_DIRECT   = 1'b0,
    GRN_INVERTED = 1'b1
  } grn_dir_e;

endpackage

// File: rtl/grn_cfg_regs.sv
module grn_cfg_regs
  import gr_norm_pkg::*;
#(
  parameter int unsigned EXP_W = GRN_CODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             inv_i,
  input  logic [EXP_W-1:0] off_i,
  output grn_dir_e         dir_o,
  output logic [EXP_W-1:0] off_o
);

  grn_dir_e         dir_q;
  logic [EXP_W-1:0] off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= GRN_DIRECT;
      off_q <= '0;
    end else if (we) begin
      dir_q <= inv_i ? GRN_INVERTED : GRN_DIRECT;
      off_q <= off_i;
    end
  end

  assign dir_o = dir_q;
  assign off_o = off_q;

endmodule

// File: rtl/grn_shift_calc.sv
module grn_shift_calc
  import gr_norm_pkg::*;
#(
  parameter int unsigned EXP_W = GRN_CODE_W
) (
  input  logic [EXP_W-1:0] code_i,
  input  grn_dir_e         dir_i,
  input  logic [EXP_W-1:0] off_i,
  output logic [EXP_W-1:0] shamt_o
);

  // Sums are truncated to EXP_W bits, which wraps them modulo 2**EXP_W.
  // For a 3-bit code, ~code is 7 - code.
  logic [EXP_W-1:0] code_eff;

  always_comb begin
    code_eff = (dir_i == GRN_INVERTED) ? ~code_i : code_i;
    shamt_o  = code_eff + off_i;
  end

endmodule

// File: rtl/grn_ashift.sv
module grn_ashift #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SH_W   = 3
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] dout
);

  // Logarithmic shifter: stage k moves the word right by 2**k when
  // bit k of the amount is set, filling the top with the sign bit.
  logic [DATA_W-1:0] stg [SH_W+1];

  assign stg[0] = din;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int unsigned STEP = 1 << k;
    always_comb begin
      if (shamt[k])
        stg[k+1] = $unsigned($signed(stg[k]) >>> STEP);
      else
        stg[k+1] = stg[k];
    end
  end

  assign dout = stg[SH_W];

endmodule

// File: rtl/gr_exp_normalizer.sv
module gr_exp_normalizer
  import gr_norm_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned EXP_W  = GRN_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_invert,
  input  logic [EXP_W-1:0]  cfg_offset,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [EXP_W-1:0]  in_exp,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  grn_dir_e          dir_q;
  logic [EXP_W-1:0]  off_q;
  logic [EXP_W-1:0]  shamt;
  logic [DATA_W-1:0] shifted;
  logic              accept;
  logic              vld_q;
  logic [DATA_W-1:0] dat_q;

  grn_cfg_regs #(.EXP_W(EXP_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .inv_i (cfg_invert),
    .off_i (cfg_offset),
    .dir_o (dir_q),
    .off_o (off_q)
  );

  grn_shift_calc #(.EXP_W(EXP_W)) u_calc (
    .code_i  (in_exp),
    .dir_i   (dir_q),
    .off_i   (off_q),
    .shamt_o (shamt)
  );

  grn_ashift #(.DATA_W(DATA_W), .SH_W(EXP_W)) u_shift (
    .din   (in_data),
    .shamt (shamt),
    .dout  (shifted)
  );

  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      if (accept) begin
        vld_q <= 1'b1;
        dat_q <= shifted;
      end else if (out_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;

endmodule

// File: rtl/gr_norm_chk.sv
module gr_norm_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data
);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R7

  AST_STALL_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R7

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R6

  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid); // R6

  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_data[DATA_W-1] == $past(in_data[DATA_W-1])); // R3

endmodule

bind gr_exp_normalizer gr_norm_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/tb_gr_exp_normalizer.sv
module tb_gr_exp_normalizer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic        cfg_invert;
  logic [2:0]  cfg_offset;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_data;
  logic [2:0]  in_exp;
  logic        out_valid;
  logic        out_ready;
  logic [15:0] out_data;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  gr_exp_normalizer dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_invert (cfg_invert),
    .cfg_offset (cfg_offset),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .in_exp     (in_exp),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data)
  );

  function automatic logic [15:0] model(input logic inv, input int off,
                                        input int code, input logic [15:0] d);
    int sh;
    sh = inv ? ((7 - code + off) % 8) : ((code + off) % 8);
    return $unsigned($signed(d) >>> sh);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic inv, input logic [2:0] off);
    @(negedge clk);
    cfg_we = 1'b1; cfg_invert = inv; cfg_offset = off;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Drive one beat at a falling edge; it is taken at the next rising edge
  // and checked at the falling edge after that.
  task automatic send_check(input string req, input logic [15:0] d,
                            input logic [2:0] e, input logic [15:0] exp);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_exp = e;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, {15'd0, out_valid}, 16'd1);
    chk(req, out_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] pats [3];
    pats[0] = 16'h8001; pats[1] = 16'h7FFF; pats[2] = 16'hA5C3;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_invert = 1'b0; cfg_offset = '0;
    in_valid = 1'b0; in_data = '0; in_exp = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 out_valid", {15'd0, out_valid}, 16'd0);
    chk("R9 in_ready", {15'd0, in_ready}, 16'd1);
    send_check("R9 zero config", 16'h4000, 3'd3, 16'h0800);

    // R1 R2 R3 full sweep
    for (int inv = 0; inv < 2; inv++) begin
      for (int off = 0; off < 8; off++) begin
        write_cfg(inv[0], off[2:0]);
        for (int e = 0; e < 8; e++) begin
          for (int p = 0; p < 3; p++) begin
            send_check(inv ? "R2 R3 inverted" : "R1 R3 direct", pats[p], e[2:0],
                       model(inv[0], off, e, pats[p]));
          end
        end
      end
    end

    // R4 invert, offset 6
    write_cfg(1'b1, 3'd6);
    for (int e = 0; e < 6; e++)
      send_check("R4", 16'h4000, e[2:0], 16'h4000 >> (5 - e));

    // R5 invert, offset 5
    write_cfg(1'b1, 3'd5);
    send_check("R5 code4", 16'hC000, 3'd4, 16'hC000);
    send_check("R5 code0", 16'h4000, 3'd0, 16'h0400);

    // R10 inputs ignored without strobe
    @(negedge clk);
    cfg_invert = 1'b0; cfg_offset = 3'd2;
    send_check("R10", 16'h4000, 3'd4, 16'h4000);

    // R8 write and sample in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_invert = 1'b0; cfg_offset = 3'd1;
    in_valid = 1'b1; in_data = 16'h4000; in_exp = 3'd4;
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    chk("R8 old setting", out_data, 16'h4000);
    send_check("R8 new setting", 16'h4000, 3'd4, 16'h0200);

    // R7 back-pressure, R6 drain
    write_cfg(1'b0, 3'd0);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = 16'h1234; in_exp = 3'd0;
    @(negedge clk);
    in_data = 16'h0F00; in_exp = 3'd4;
    chk("R7 held valid", {15'd0, out_valid}, 16'd1);
    chk("R7 in_ready low", {15'd0, in_ready}, 16'd0);
    @(negedge clk);
    chk("R7 data held", out_data, 16'h1234);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6 next beat", out_data, 16'h00F0);
    chk("R6 next valid", {15'd0, out_valid}, 16'd1);
    @(negedge clk);
    chk("R6 drained", {15'd0, out_valid}, 16'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule